// File: doc/BRIEF.md
# Chained-Shifter Parallel Burst Transmitter

This block sends bursts of data as 8-bit parallel beats. It holds a bank of 32-bit word buffers that software fills over a plain write port. Behind the buffers sits a chain of 32-bit shift stages. Each stage takes its incoming byte from the stage above it, and only stage 0 drives the output pins. Writes to the lower buffers only stage data. A write to the highest-indexed buffer arms a burst and raises a request that starts an external shift timer. That timer returns one `shift_tick` pulse per rising edge of its shift clock.

On the first tick after arming, all buffers move into the shift stages and the first beat is presented. The consumed-buffer status flag is set at that moment, so software may refill the buffers while the burst shifts out. Each later tick shifts one beat. A programmable beat count lets a final partial burst end early; software zero-pads the unused buffer bytes. After the last beat the pins hold their value. A burst armed before then starts on the very next tick with no gap.

Top module: `parallel_burst_tx`

## Requirements
- R1: After reset, `pin_data` is 0, and `burst_req`, `busy`, `buf_empty` and `irq` are all 0. The beat count is the full burst (4 beats per buffer, 16 with four buffers).
- R2: A write to a buffer below the top one (address 0 to NSH-2) does not raise `burst_req`. Ticks that arrive while nothing is armed leave `pin_data` unchanged.
- R3: A write to the top buffer (address NSH-1) sets `burst_req` from the next cycle. The tick that loads the burst clears it, unless the top buffer is written in that same cycle.
- R4: Beat k of a burst is byte k mod 4 of buffer k/4, taking bits 8*(k mod 4) upward, so the order is little-endian. The first beat appears on the loading tick. Each later tick presents exactly one new beat, and `pin_data` never changes in a cycle without a tick.
- R5: A write to address NSH sets the beat count to wr_data for values from 1 to 4*NSH. A value of 0, or anything above 4*NSH, selects the full 4*NSH. Once the last beat is out, further ticks leave `pin_data` holding that beat.
- R6: `buf_empty` is set by the loading tick. Writing 1 to bit 0 at address NSH+1 clears it. When a load and such a clear fall in the same cycle, the flag ends up set.
- R7: `irq` is 1 exactly when `buf_empty` is 1 and the enable bit is 1. The enable bit is bit 0 at address NSH+2 and is 0 after reset.
- R8: Buffer writes made while a burst shifts do not alter that burst's beats. If the burst is re-armed before its last beat, the next tick after that beat loads the new burst.
- R9: `busy` is 1 while beats of the current burst remain to be presented after the one on the pins. It is 0 once the last beat is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: buffers, beat count, status, enable |
| wr_data | input | 32 | Write data |
| shift_tick | input | 1 | One-cycle pulse per shift-clock rising edge from the timer |
| pin_data | output | 8 | Parallel beat output driven by stage 0 |
| burst_req | output | 1 | Burst armed; trigger for the shift timer |
| busy | output | 1 | More beats of the current burst remain |
| buf_empty | output | 1 | Buffers consumed into the shift stages (write 1 to clear) |
| irq | output | 1 | Buffer-empty interrupt |

## Verification
Two events can fall in one cycle. The loading tick sets the empty flag while software writes 1 to the status register to clear it. The bench provokes this by driving a status clear on the same cycle as the tick that consumes an armed burst. It then requires the flag to read 1, and a later clear on its own to read 0. A second overlap is also exercised: refilling and re-arming the buffers while a full burst is still shifting. Every beat of both bursts is compared against bytes the bench computes arithmetically.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int unsigned BEAT_W         = 8;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned BEATS_PER_WORD = WORD_W / BEAT_W;

  // Requested beat count -> effective count; out-of-range picks a full burst.
  function automatic int unsigned eff_beats(input int unsigned req,
                                            input int unsigned total);
    return ((req == 0) || (req > total)) ? total : req;
  endfunction
endpackage

// File: rtl/ptx_buffer_bank.sv
module ptx_buffer_bank
  import ptx_pkg::*;
#(
  parameter int unsigned NSH = 4,
  parameter int unsigned AW  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  output logic [NSH-1:0][WORD_W-1:0]    words,
  output logic                          top_write
);
  localparam logic [AW-1:0] TOP_A = AW'(NSH - 1);

  assign top_write = wr_en && (wr_addr == TOP_A);

  for (genvar i = 0; i < NSH; i++) begin : g_buf
    localparam logic [AW-1:0] MY_A = AW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         words[i] <= '0;
      else if (wr_en && wr_addr == MY_A)  words[i] <= wr_data;
    end
  end
endmodule

// File: rtl/ptx_shift_chain.sv
module ptx_shift_chain
  import ptx_pkg::*;
#(
  parameter int unsigned NSH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          shift,
  input  logic [NSH-1:0][WORD_W-1:0]    load_words,
  output logic [BEAT_W-1:0]             pin_data
);
  logic [NSH-1:0][WORD_W-1:0] stg;

  for (genvar i = 0; i < NSH; i++) begin : g_stage
    logic [BEAT_W-1:0] in_shift;
    logic [BEAT_W-1:0] in_load;
    if (i == NSH - 1) begin : g_top
      assign in_shift = '0;
      assign in_load  = '0;
    end else begin : g_mid
      assign in_shift = stg[i+1][BEAT_W-1:0];
      assign in_load  = load_words[i+1][BEAT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[i] <= '0;
      else if (load)   stg[i] <= {in_load, load_words[i][WORD_W-1:BEAT_W]};
      else if (shift)  stg[i] <= {in_shift, stg[i][WORD_W-1:BEAT_W]};
    end
  end

  // Only stage 0 reaches the pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_data <= '0;
    else if (load)   pin_data <= load_words[0][BEAT_W-1:0];
    else if (shift)  pin_data <= stg[0][BEAT_W-1:0];
  end
endmodule

// File: rtl/ptx_burst_ctrl.sv
module ptx_burst_ctrl
  import ptx_pkg::*;
#(
  parameter int unsigned NSH = 4,
  parameter int unsigned AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              top_write,
  input  logic              shift_tick,
  output logic              load,
  output logic              shift,
  output logic              burst_req,
  output logic              busy,
  output logic              buf_empty,
  output logic              irq
);
  localparam int unsigned TOTAL = NSH * BEATS_PER_WORD;
  localparam int unsigned CW    = $clog2(TOTAL + 1);
  localparam logic [AW-1:0] LEN_A  = AW'(NSH);
  localparam logic [AW-1:0] STAT_A = AW'(NSH + 1);
  localparam logic [AW-1:0] IE_A   = AW'(NSH + 2);

  logic          armed_q;
  logic          flag_q;
  logic          ie_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] left_q;
  logic          clr_req;

  assign load    = shift_tick && armed_q && (left_q == '0);
  assign shift   = shift_tick && (left_q != '0);
  assign clr_req = wr_en && (wr_addr == STAT_A) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      len_q   <= CW'(TOTAL);
      left_q  <= '0;
    end else begin
      if (top_write)     armed_q <= 1'b1;
      else if (load)     armed_q <= 1'b0;

      if (load)          flag_q <= 1'b1;   // set beats clear
      else if (clr_req)  flag_q <= 1'b0;

      if (wr_en && wr_addr == IE_A)  ie_q  <= wr_data[0];
      if (wr_en && wr_addr == LEN_A) len_q <= CW'(eff_beats(wr_data, TOTAL));

      if (load)          left_q <= len_q - CW'(1);
      else if (shift)    left_q <= left_q - CW'(1);
    end
  end

  assign burst_req = armed_q;
  assign busy      = (left_q != '0);
  assign buf_empty = flag_q;
  assign irq       = flag_q && ie_q;
endmodule

// File: rtl/parallel_burst_tx.sv
module parallel_burst_tx
  import ptx_pkg::*;
#(
  parameter int unsigned NSH = 4,
  parameter int unsigned AW  = $clog2(NSH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              shift_tick,
  output logic [7:0]        pin_data,
  output logic              burst_req,
  output logic              busy,
  output logic              buf_empty,
  output logic              irq
);
  logic [NSH-1:0][WORD_W-1:0] buf_words;
  logic                       top_write;
  logic                       load_evt;
  logic                       shift_evt;

  ptx_buffer_bank #(.NSH(NSH), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .words(buf_words), .top_write(top_write)
  );

  ptx_burst_ctrl #(.NSH(NSH), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .top_write(top_write), .shift_tick(shift_tick),
    .load(load_evt), .shift(shift_evt), .burst_req(burst_req),
    .busy(busy), .buf_empty(buf_empty), .irq(irq)
  );

  ptx_shift_chain #(.NSH(NSH)) u_chain (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .shift(shift_evt),
    .load_words(buf_words), .pin_data(pin_data)
  );
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
  parameter int unsigned NSH = 4,
  parameter int unsigned AW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          shift_tick,
  input logic [7:0]    pin_data,
  input logic          burst_req,
  input logic          buf_empty,
  input logic          irq,
  input logic          load_evt
);
  localparam logic [AW-1:0] TOP_A = AW'(NSH - 1);
  logic top_wr;
  assign top_wr = wr_en && (wr_addr == TOP_A);

  a_r2_no_arm_without_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_req && !top_wr) |=> !burst_req);

  a_r3_req_clears_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !top_wr) |=> !burst_req);

  a_r4_pins_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_tick |=> $stable(pin_data));

  a_r6_flag_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> buf_empty);

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> buf_empty);
endmodule

bind parallel_burst_tx ptx_checker #(.NSH(NSH), .AW(AW)) u_ptx_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .shift_tick(shift_tick), .pin_data(pin_data), .burst_req(burst_req),
  .buf_empty(buf_empty), .irq(irq), .load_evt(load_evt)
);

// File: tb/parallel_burst_tx_bench.sv
module parallel_burst_tx_bench;
  localparam int NSH = 4;
  localparam int AW  = 3;
  localparam int TOT = NSH * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          shift_tick = 1'b0;
  logic [7:0]    pin_data;
  logic          burst_req, busy, buf_empty, irq;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  parallel_burst_tx #(.NSH(NSH), .AW(AW)) u_parallel_burst_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .shift_tick(shift_tick), .pin_data(pin_data),
    .burst_req(burst_req), .busy(busy), .buf_empty(buf_empty), .irq(irq)
  );

  function automatic logic [7:0] bval(int l, int k);
    return 8'((l * 17 + k * 5 + 3) & 255);
  endfunction

  function automatic logic [31:0] wval(int l, int i);
    return {bval(l, 4*i+3), bval(l, 4*i+2), bval(l, 4*i+1), bval(l, 4*i)};
  endfunction

  function automatic int effl(int l);
    return (l == 0 || l > TOT) ? TOT : l;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample at the next negedge.
  task automatic step(input logic t, input logic we, input int a, input logic [31:0] d);
    shift_tick = t; wr_en = we; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    shift_tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic load_bufs(input int l);
    for (int i = 0; i < NSH - 1; i++) step(1'b0, 1'b1, i, wval(l, i));
  endtask

  // Arm, then emit a whole burst and check every beat.
  task automatic run_burst(input int l, input int n);
    logic [7:0] prev;
    load_bufs(l);
    chk("R2 lower writes do not arm", burst_req, 0);
    prev = pin_data;
    step(1'b1, 1'b0, 0, 0);
    chk("R2 unarmed tick holds pins", pin_data, prev);
    step(1'b0, 1'b1, NSH - 1, wval(l, NSH - 1));
    chk("R3 top write arms", burst_req, 1);
    step(1'b1, 1'b0, 0, 0);
    chk("R3 load clears request", burst_req, 0);
    chk("R6 load sets empty flag", buf_empty, 1);
    chk("R4 first beat", pin_data, bval(l, 0));
    chk("R9 busy after load", busy, (n > 1) ? 1 : 0);
    for (int k = 1; k < n; k++) begin
      if (k % 3 == 0) begin
        step(1'b0, 1'b0, 0, 0);
        chk("R4 no tick no change", pin_data, bval(l, k - 1));
      end
      step(1'b1, 1'b0, 0, 0);
      chk("R4 beat order", pin_data, bval(l, k));
      chk("R9 busy during burst", busy, (k < n - 1) ? 1 : 0);
    end
    step(1'b1, 1'b0, 0, 0);
    step(1'b1, 1'b0, 0, 0);
    chk("R5 pins hold after last beat", pin_data, bval(l, n - 1));
    chk("R9 idle after burst", busy, 0);
    step(1'b0, 1'b1, NSH + 1, 32'h1);
    chk("R6 write-1 clears flag", buf_empty, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pins", pin_data, 0);
    chk("R1 reset req", burst_req, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset flag", buf_empty, 0);
    chk("R1 reset irq", irq, 0);

    // R1: default beat count is a full burst.
    run_burst(20, TOT);

    // R5 sweep of every beat-count value, including out of range.
    for (int l = 0; l <= TOT + 1; l++) begin
      step(1'b0, 1'b1, NSH, 32'(l));
      run_burst(l, effl(l));
    end
    step(1'b0, 1'b1, NSH, 32'h100);
    run_burst(7, TOT);

    // R6: load and status clear in the same cycle; set wins.
    step(1'b0, 1'b1, NSH, 32'(TOT));
    load_bufs(30);
    step(1'b0, 1'b1, NSH - 1, wval(30, NSH - 1));
    step(1'b1, 1'b1, NSH + 1, 32'h1);
    chk("R6 set beats simultaneous clear", buf_empty, 1);
    chk("R4 first beat at collision", pin_data, bval(30, 0));

    // R7: interrupt follows flag and enable.
    chk("R7 irq off while disabled", irq, 0);
    step(1'b0, 1'b1, NSH + 2, 32'h1);
    chk("R7 irq with flag and enable", irq, 1);
    step(1'b0, 1'b1, NSH + 1, 32'h1);
    chk("R6 lone clear", buf_empty, 0);
    chk("R7 irq drops with flag", irq, 0);

    // R8: refill and re-arm during burst 30; beats unaffected, no gap.
    for (int i = 0; i < NSH; i++) begin
      step(1'b1, 1'b0, 0, 0);
      chk("R8 current burst intact", pin_data, bval(30, i + 1));
      step(1'b0, 1'b1, i, wval(31, i));
    end
    chk("R8 re-armed", burst_req, 1);
    for (int k = NSH + 1; k < TOT; k++) begin
      step(1'b1, 1'b0, 0, 0);
      chk("R8 current burst intact", pin_data, bval(30, k));
    end
    step(1'b1, 1'b0, 0, 0);
    chk("R8 next burst without gap", pin_data, bval(31, 0));
    chk("R7 irq on reload", irq, 1);
    for (int k = 1; k < TOT; k++) begin
      step(1'b1, 1'b0, 0, 0);
      chk("R8 second burst", pin_data, bval(31, k));
    end
    chk("R9 idle at end", busy, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule